// File: doc/BRIEF.md
# Watchdog Timer with Prescaler and Timed Reset Pulse

This block is a free-running software watchdog. A prescaler of `PRE_W` bits counts every oscillator clock. Each carry out of the prescaler advances a `CNT_W`-bit timeout counter. When a prescaler carry arrives while the timeout counter is at all ones, the watchdog has expired. It then drives an active-low reset output for `PULSE_LEN` clocks and sets a sticky status flag. Software keeps the watchdog quiet by writing any value to the control address (`svc_wr`) often enough. A service clears the timeout counter and the upper prescaler bits from `KEEP_W` upward. The lowest `KEEP_W` prescaler bits keep counting.

A read of the control address (`ctl_rd`) returns the constant byte on `vec_lo`, not any counter state. A stop strobe clears the whole prescaler. The prescaler is also cleared once, `POR_DELAY` clocks after the power-on reset is released. Two conditions disable the watchdog: a monitor-mode input together with a high-voltage indication on either the reset pin or the interrupt pin, and a break-state input together with a high-voltage indication on the reset pin. The high-voltage indications are plain digital inputs.

A four-state machine sequences the block:
- `ST_POR_WAIT`: counts the power-up delay. The prescaler runs.
- `ST_RUN`: normal counting.
- `ST_HOLD`: disabled. The prescaler and the counter are held at zero.
- `ST_PULSE`: the reset output is driven low.

The transitions are:
- POR_WAIT→RUN when the delay ends.
- POR_WAIT→HOLD when the delay ends while the block is disabled.
- RUN→HOLD on disable.
- RUN→PULSE on an unserviced overflow.
- HOLD→RUN when the disable is removed.
- PULSE→RUN after `PULSE_LEN` clocks.
- PULSE→HOLD after `PULSE_LEN` clocks while the block is disabled.

Top module: `svc_watchdog`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is 1, `cop_flag` is 0, and `rd_data` is 0 whenever `ctl_rd` is low.
- R2: The prescaler increments every clock. A carry happens in a cycle where it is all ones, and each carry increments the timeout counter. Expiry is a carry while the counter is all ones. From a prescaler and counter both at zero, expiry takes exactly 2^(PRE_W+CNT_W) clocks.
- R3: On expiry, `rst_out_n` goes low at the next edge and stays low for exactly `PULSE_LEN` clocks. The prescaler and the counter are zero when the pulse ends.
- R4: `cop_flag` is set at the edge where the pulse starts and stays set after the pulse. A `stat_rd` cycle clears it at the next edge unless an expiry sets it in that same cycle. Reading the status does not change the timing.
- R5: A `svc_wr` cycle clears the counter and prescaler bits PRE_W-1..KEEP_W. The low KEEP_W bits still increment at that edge. A service in the overflow cycle prevents the expiry. A service during the pulse has no effect.
- R6: While `ctl_rd` is high, `rd_data` equals `vec_lo`; otherwise it is 0. A read does not service the watchdog.
- R7: A `stop_clr` cycle sets the whole prescaler to zero and leaves the timeout counter unchanged.
- R8: The prescaler is cleared once, at the `POR_DELAY`-th clock edge after `por_n` rises.
- R9: The block is disabled when (`mon_mode` and (`rstpin_hv` or `irqpin_hv`)) or (`brk_state` and `rstpin_hv`). `brk_state` with only `irqpin_hv` does not disable it.
- R10: While disabled, no pulse starts and the counters are held at zero. When the disable is removed, a full 2^(PRE_W+CNT_W) period is counted from the first edge without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| svc_wr | input | 1 | Write strobe to the control address (service) |
| ctl_rd | input | 1 | Read strobe of the control address |
| stat_rd | input | 1 | Read strobe of the status flag; clears it |
| stop_clr | input | 1 | Stop-instruction strobe; clears the prescaler |
| mon_mode | input | 1 | Monitor mode active |
| brk_state | input | 1 | Break state active |
| rstpin_hv | input | 1 | Test voltage present on the reset pin |
| irqpin_hv | input | 1 | Test voltage present on the interrupt pin |
| vec_lo | input | VEC_W | Constant byte returned by control reads |
| rd_data | output | VEC_W | Read data of the control address |
| cop_flag | output | 1 | Sticky watchdog-expiry flag |
| rst_out_n | output | 1 | Reset pulse output, active low |

## Verification
The bench uses a small configuration (4-bit prescaler, 2 low bits kept, 2-bit counter). It sweeps the service time across the whole period, including the overflow cycle itself. The expected expiry edge is computed from the surviving low prescaler bits. A design that also cleared the low bits, or one that let the overflow win over a service, would expire a few clocks early or late. All sixteen combinations of the four disable inputs are applied, so a wrong disable equation either pulses while it should hold or holds while it should pulse. The power-up clear, the stop strobe taken before and after a carry, and a service held during the pulse each shift the expiry edge by a computable amount if they are mishandled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_POR_WAIT = 2'd0,
        ST_RUN      = 2'd1,
        ST_HOLD     = 2'd2,
        ST_PULSE    = 2'd3
    } wdt_state_e;

    // Disable decode shared by the design and its checker.
    function automatic logic wdt_disabled(input logic mon, input logic brk,
                                          input logic rst_hv, input logic irq_hv);
        return (mon && (rst_hv || irq_hv)) || (brk && rst_hv);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W  = 13,
    parameter int KEEP_W = 5
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run_i,
    input  logic             clr_all_i,
    input  logic             clr_upper_i,
    output logic             carry_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] svc_val;

    generate
        if (KEEP_W == 0) begin : g_clear_all
            assign svc_val = '0;
        end else begin : g_keep_low
            logic [KEEP_W-1:0] lo_next;
            assign lo_next = pre_q[KEEP_W-1:0] + KEEP_W'(1);
            assign svc_val = {{(PRE_W-KEEP_W){1'b0}}, lo_next};
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= '0;
        end else if (clr_all_i) begin
            pre_q <= '0;
        end else if (clr_upper_i) begin
            pre_q <= svc_val;
        end else if (run_i) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign carry_o = run_i && (&pre_q);

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic ovf_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign ovf_o = inc_i && (&cnt_q);

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int POR_DELAY = 4096,
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic dis_i,
    input  logic ovf_i,
    input  logic svc_i,
    output logic pre_run_o,
    output logic pre_clr_o,
    output logic cnt_clr_o,
    output logic timeout_o,
    output logic rst_n_o
);
    localparam int POR_W   = $clog2(POR_DELAY + 1);
    localparam int PULSE_W = $clog2(PULSE_LEN + 1);

    wdt_state_e       state_q, state_d;
    logic [POR_W-1:0]   por_cnt_q;
    logic [PULSE_W-1:0] pulse_cnt_q;
    logic               por_done;
    logic               pulse_done;

    assign por_done   = (state_q == ST_POR_WAIT) && (por_cnt_q == POR_W'(POR_DELAY - 1));
    assign pulse_done = (state_q == ST_PULSE) && (pulse_cnt_q == PULSE_W'(PULSE_LEN - 1));

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POR_WAIT: if (por_done)                     state_d = dis_i ? ST_HOLD : ST_RUN;
            ST_RUN: begin
                if (dis_i)                                 state_d = ST_HOLD;
                else if (ovf_i && !svc_i)                  state_d = ST_PULSE;
            end
            ST_HOLD:     if (!dis_i)                       state_d = ST_RUN;
            ST_PULSE:    if (pulse_done)                   state_d = dis_i ? ST_HOLD : ST_RUN;
        endcase
    end

    // State register and sequencing counters
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q     <= ST_POR_WAIT;
            por_cnt_q   <= '0;
            pulse_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_POR_WAIT) begin
                por_cnt_q <= por_cnt_q + POR_W'(1);
            end
            if (state_q == ST_PULSE) begin
                pulse_cnt_q <= pulse_cnt_q + PULSE_W'(1);
            end else begin
                pulse_cnt_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        pre_run_o = (state_q == ST_POR_WAIT) || (state_q == ST_RUN);
        pre_clr_o = dis_i || (state_q == ST_HOLD) || (state_q == ST_PULSE) || por_done;
        cnt_clr_o = dis_i || (state_q == ST_HOLD) || (state_q == ST_PULSE) || svc_i;
        timeout_o = (state_q == ST_RUN) && !dis_i && ovf_i && !svc_i;
        rst_n_o   = (state_q != ST_PULSE);
    end

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdt_pkg::*;
#(
    parameter int PRE_W     = 13,
    parameter int KEEP_W    = 5,
    parameter int CNT_W     = 6,
    parameter int PULSE_LEN = 32,
    parameter int POR_DELAY = 4096,
    parameter int VEC_W     = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             svc_wr,
    input  logic             ctl_rd,
    input  logic             stat_rd,
    input  logic             stop_clr,
    input  logic             mon_mode,
    input  logic             brk_state,
    input  logic             rstpin_hv,
    input  logic             irqpin_hv,
    input  logic [VEC_W-1:0] vec_lo,
    output logic [VEC_W-1:0] rd_data,
    output logic             cop_flag,
    output logic             rst_out_n
);
    logic dis;
    logic pre_run, pre_clr, cnt_clr, timeout;
    logic carry, ovf;
    logic flag_q;

    assign dis = wdt_disabled(mon_mode, brk_state, rstpin_hv, irqpin_hv);

    wdt_fsm #(
        .POR_DELAY (POR_DELAY),
        .PULSE_LEN (PULSE_LEN)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .dis_i     (dis),
        .ovf_i     (ovf),
        .svc_i     (svc_wr),
        .pre_run_o (pre_run),
        .pre_clr_o (pre_clr),
        .cnt_clr_o (cnt_clr),
        .timeout_o (timeout),
        .rst_n_o   (rst_out_n)
    );

    wdt_prescaler #(
        .PRE_W  (PRE_W),
        .KEEP_W (KEEP_W)
    ) u_pre (
        .clk         (clk),
        .por_n       (por_n),
        .run_i       (pre_run),
        .clr_all_i   (pre_clr || stop_clr),
        .clr_upper_i (svc_wr),
        .carry_o     (carry)
    );

    wdt_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .clr_i (cnt_clr),
        .inc_i (carry),
        .ovf_o (ovf)
    );

    // Sticky expiry flag: set wins over a status read
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (timeout) begin
            flag_q <= 1'b1;
        end else if (stat_rd) begin
            flag_q <= 1'b0;
        end
    end

    assign cop_flag = flag_q;
    assign rd_data  = ctl_rd ? vec_lo : '0;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 32,
    parameter int VEC_W     = 8
) (
    input logic             clk,
    input logic             por_n,
    input logic             svc_wr,
    input logic             ctl_rd,
    input logic             stat_rd,
    input logic             mon_mode,
    input logic             brk_state,
    input logic             rstpin_hv,
    input logic             irqpin_hv,
    input logic [VEC_W-1:0] vec_lo,
    input logic [VEC_W-1:0] rd_data,
    input logic             cop_flag,
    input logic             rst_out_n
);
    localparam int LR_W = $clog2(PULSE_LEN + 2);

    logic [LR_W-1:0] low_run;
    logic            dis_now;

    assign dis_now = wdt_disabled(mon_mode, brk_state, rstpin_hv, irqpin_hv);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          low_run <= '0;
        else if (rst_out_n)  low_run <= '0;
        else                 low_run <= low_run + LR_W'(1);
    end

    // R1: reset state of the outputs
    a_r1_reset_idle: assert property (@(posedge clk) !por_n |-> (rst_out_n && !cop_flag));

    // R3: the pulse ends after exactly PULSE_LEN low cycles
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> (low_run == LR_W'(PULSE_LEN)));

    // R4: the flag is set when the pulse starts
    a_r4_flag_on_pulse: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out_n) |-> cop_flag);

    // R4: the flag stays set without a status read
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (cop_flag && !stat_rd) |=> cop_flag);

    // R5: a service keeps the next cycle out of the pulse
    a_r5_service_blocks: assert property (@(posedge clk) disable iff (!por_n)
        (svc_wr && rst_out_n) |=> rst_out_n);

    // R6: control reads return the constant byte
    a_r6_read_value: assert property (@(posedge clk) disable iff (!por_n)
        ctl_rd |-> (rd_data == vec_lo));

    // R10: no pulse starts while disabled
    a_r10_no_pulse_disabled: assert property (@(posedge clk) disable iff (!por_n)
        (dis_now && rst_out_n) |=> rst_out_n);

endmodule

bind svc_watchdog wdt_checker #(
    .PULSE_LEN (PULSE_LEN),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .svc_wr    (svc_wr),
    .ctl_rd    (ctl_rd),
    .stat_rd   (stat_rd),
    .mon_mode  (mon_mode),
    .brk_state (brk_state),
    .rstpin_hv (rstpin_hv),
    .irqpin_hv (irqpin_hv),
    .vec_lo    (vec_lo),
    .rd_data   (rd_data),
    .cop_flag  (cop_flag),
    .rst_out_n (rst_out_n)
);

// File: tb/tb_svc_watchdog.sv
`timescale 1ns/1ps
module tb_svc_watchdog;
    localparam int PRE_W     = 4;
    localparam int KEEP_W    = 2;
    localparam int CNT_W     = 2;
    localparam int PULSE_LEN = 4;
    localparam int POR_DELAY = 8;
    localparam int PERIOD    = 1 << (PRE_W + CNT_W);
    localparam int PRE_SPAN  = 1 << PRE_W;
    localparam int KEEP_SPAN = 1 << KEEP_W;
    localparam int CNT_SPAN  = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic       svc_wr = 1'b0, ctl_rd = 1'b0, stat_rd = 1'b0, stop_clr = 1'b0;
    logic       mon_mode = 1'b0, brk_state = 1'b0, rstpin_hv = 1'b0, irqpin_hv = 1'b0;
    logic [7:0] vec_lo = 8'h5A;
    logic [7:0] rd_data;
    logic       cop_flag, rst_out_n;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int k0 = 0;

    svc_watchdog #(
        .PRE_W(PRE_W), .KEEP_W(KEEP_W), .CNT_W(CNT_W),
        .PULSE_LEN(PULSE_LEN), .POR_DELAY(POR_DELAY), .VEC_W(8)
    ) dut (
        .clk(clk), .por_n(por_n), .svc_wr(svc_wr), .ctl_rd(ctl_rd),
        .stat_rd(stat_rd), .stop_clr(stop_clr), .mon_mode(mon_mode),
        .brk_state(brk_state), .rstpin_hv(rstpin_hv), .irqpin_hv(irqpin_hv),
        .vec_lo(vec_lo), .rd_data(rd_data), .cop_flag(cop_flag), .rst_out_n(rst_out_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_until(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    // One-cycle strobe that is sampled at edge e
    task automatic strobe_svc(input int e);
        wait_until(e - 1);
        svc_wr = 1'b1;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic strobe_stop(input int e);
        wait_until(e - 1);
        stop_clr = 1'b1;
        @(negedge clk);
        stop_clr = 1'b0;
    endtask

    // Expect the pulse to start at edge exp, then check its length
    task automatic expect_timeout(input int exp, input string tag);
        int fe;
        int lows;
        while (rst_out_n && cyc <= exp + 4) @(negedge clk);
        fe = rst_out_n ? -1 : cyc;
        check(fe == exp, tag, fe, exp);
        if (fe < 0) begin
            k0 = cyc;
        end else begin
            lows = 0;
            while (!rst_out_n && lows < 100) begin
                lows++;
                @(negedge clk);
            end
            check(lows == PULSE_LEN, "R3 pulse length", lows, PULSE_LEN);
            k0 = fe + PULSE_LEN;
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int rel;
        #1 por_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rst_out_n == 1'b1, "R1 reset rst_out_n", int'(rst_out_n), 1);
        check(cop_flag == 1'b0, "R1 reset cop_flag", int'(cop_flag), 0);
        check(rd_data == 8'h00, "R1 reset rd_data", int'(rd_data), 0);

        // R8 + R2: power-up clear then a full period
        rel = cyc;
        por_n = 1'b1;
        expect_timeout(rel + POR_DELAY + PERIOD, "R8 R2 first expiry after power-up");

        // R4 flag sticky, then cleared by a status read
        check(cop_flag == 1'b1, "R4 flag after pulse", int'(cop_flag), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check(cop_flag == 1'b0, "R4 flag cleared by status read", int'(cop_flag), 0);
        expect_timeout(k0 + PERIOD, "R4 status read leaves timing");

        // R5 service sweep across the period, last one in the overflow cycle
        for (int s = 0; s <= 21; s++) begin
            int e;
            int exp;
            e = k0 + 3 * s + 1;
            strobe_svc(e);
            exp = e + PERIOD - ((e - k0) % KEEP_SPAN);
            expect_timeout(exp, $sformatf("R5 service sweep step %0d", s));
        end

        // R6 reads return vec_lo and do not service
        for (int i = 0; i < 8; i++) begin
            logic [7:0] pat;
            pat = 8'((i * 37 + 11) ^ (i << 5));
            vec_lo = pat;
            ctl_rd = 1'b1;
            #1;
            check(rd_data == pat, "R6 read value", int'(rd_data), int'(pat));
            @(negedge clk);
        end
        ctl_rd = 1'b0;
        #1;
        check(rd_data == 8'h00, "R6 idle read data", int'(rd_data), 0);
        expect_timeout(k0 + PERIOD, "R6 reads do not service");

        // R7 stop strobe before and after a carry
        for (int j = 0; j < 2; j++) begin
            int d;
            int e;
            d = (j == 0) ? 20 : 40;
            e = k0 + d;
            strobe_stop(e);
            expect_timeout(e + PRE_SPAN * (CNT_SPAN - d / PRE_SPAN),
                           $sformatf("R7 stop strobe at offset %0d", d));
        end

        // R5 service held during the pulse has no effect
        begin
            int f;
            int lows;
            f = k0 + PERIOD;
            wait_until(f);
            check(rst_out_n == 1'b0, "R3 pulse start before held service", int'(rst_out_n), 0);
            svc_wr = 1'b1;
            lows = 0;
            while (!rst_out_n && lows < 100) begin
                lows++;
                @(negedge clk);
            end
            svc_wr = 1'b0;
            check(lows == PULSE_LEN, "R5 service during pulse keeps length", lows, PULSE_LEN);
            k0 = f + PULSE_LEN;
            expect_timeout(k0 + PERIOD, "R5 service during pulse ignored");
        end

        // R9 / R10 all combinations of the disable inputs
        for (int c = 0; c < 16; c++) begin
            bit m, b, r, q, dis;
            int lows;
            int base;
            m = c[0]; b = c[1]; r = c[2]; q = c[3];
            dis = (m && (r || q)) || (b && r);
            base = k0;
            mon_mode = m; brk_state = b; rstpin_hv = r; irqpin_hv = q;
            if (dis) begin
                lows = 0;
                while (cyc < base + 100) begin
                    @(negedge clk);
                    if (!rst_out_n) lows++;
                end
                check(lows == 0, $sformatf("R10 no pulse while disabled combo %0d", c), lows, 0);
                mon_mode = 0; brk_state = 0; rstpin_hv = 0; irqpin_hv = 0;
                k0 = base + 101;
                expect_timeout(k0 + PERIOD, $sformatf("R10 full period after release combo %0d", c));
            end else begin
                expect_timeout(base + PERIOD, $sformatf("R9 enabled combo %0d", c));
                mon_mode = 0; brk_state = 0; rstpin_hv = 0; irqpin_hv = 0;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule